// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block watches the register indices moving through a five-stage in-order integer pipeline (fetch, decode, execute, memory access, writeback). It decides two things each cycle. First, whether the two ALU operands of the instruction in execute should be taken from a later pipeline register instead of the register file. Second, whether fetch and decode must freeze while a bubble enters execute. It is purely combinational. The surrounding datapath supplies the source indices and use flags of the decoding instruction, the source indices of the executing instruction, and the destination, write-enable and load flag of the producers further down the pipe.

A compile-time parameter selects one of three hazard strategies. In stall-only mode the block never bypasses and freezes decode until every producer has reached writeback. The register file is assumed to write in the first half of a cycle and read in the second half. In forward-only mode the block never freezes, so software must keep a gap after every load. In combined mode the block bypasses wherever it can and freezes for a single cycle only when a load in execute feeds the decoding instruction.

Top module: `hazard_ctrl`

## Requirements
- R1: Parameter `MODE` selects the strategy: 0 means stall-only, 1 means forward-only and 2 means combined. Any other value, or an index width outside 1 to 8, stops elaboration.
- R2: Each operand select is 2 bits. 2'b00 takes the register file, 2'b10 takes the memory-stage result and 2'b01 takes the writeback-stage result. 2'b11 never appears.
- R3: When the memory-stage and writeback-stage producers both write the execute operand's register, the memory-stage result (2'b10) is selected.
- R4: Register index 0 never creates a dependency, and neither does a producer whose write-enable is low. This holds for both bypass and freeze decisions.
- R5: A memory-stage producer flagged as a load is never bypassed from the memory stage. The select falls through to a writeback match, or to 2'b00 if there is none.
- R6: In stall-only mode, both selects stay at 2'b00. The freeze is raised exactly when a used decode source matches a writing destination in execute or memory. A writeback-stage match alone never freezes.
- R7: In forward-only mode, the freeze is never raised. The selects follow R2 to R5.
- R8: In combined mode, the selects follow R2 to R5. The freeze is raised exactly when the execute-stage producer is a load and its writing destination matches a used decode source.
- R9: The PC hold, IF/ID hold and ID/EX bubble outputs are always equal.
- R10: A decode source whose use flag is low never raises the freeze.
- R11: In combined mode a load-use pair freezes for exactly one cycle. On the next cycle, with the load in memory and a bubble in execute, no freeze is raised. On the cycle after that, the consumer in execute receives the writeback bypass (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source index of the decoding instruction |
| id_rs2_i | input | REG_AW | Second source index of the decoding instruction |
| id_use_rs1_i | input | 1 | Decoding instruction reads its first source |
| id_use_rs2_i | input | 1 | Decoding instruction reads its second source |
| ex_rs1_i | input | REG_AW | First source index of the executing instruction |
| ex_rs2_i | input | REG_AW | Second source index of the executing instruction |
| ex_rd_i | input | REG_AW | Destination of the executing instruction |
| ex_wen_i | input | 1 | Executing instruction writes a register |
| ex_load_i | input | 1 | Executing instruction is a load |
| mem_rd_i | input | REG_AW | Destination of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | REG_AW | Destination of the writeback-stage instruction |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_sel_o | output | 2 | Select for the first ALU operand multiplexer |
| fwd_b_sel_o | output | 2 | Select for the second ALU operand multiplexer |
| pc_hold_o | output | 1 | Keep the program counter unchanged |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble_o | output | 1 | Load a bubble into the decode/execute register |

## Verification
The checker treats every input combination as legal and assumes only that the inputs have settled before outputs are judged. It relies on no ordering between stages: a load flag may be set together with a low write-enable, and sources may match several producers at once. The stimulus therefore walks every combination of a 2-bit index configuration, covering indices, use flags, write-enables and load flags, with inputs changed away from the clock edge. It also replays a short load-use sequence to confirm the single-cycle freeze.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   localparam int HZ_STALL_ONLY = 0;
   localparam int HZ_FWD_ONLY   = 1;
   localparam int HZ_COMBINED   = 2;

   typedef enum logic [1:0] {
      OPSEL_RF  = 2'b00,
      OPSEL_WB  = 2'b01,
      OPSEL_MEM = 2'b10
   } opsel_e;

   function automatic bit mode_legal(input int m);
      return (m == HZ_STALL_ONLY) || (m == HZ_FWD_ONLY) || (m == HZ_COMBINED);
   endfunction

endpackage

// File: rtl/hzd_reg_match.sv
module hzd_reg_match #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src_i,
   input  logic          src_en_i,
   input  logic [AW-1:0] dst_i,
   input  logic          dst_wen_i,
   output logic          hit_o
);
   localparam logic [AW-1:0] ZERO_IDX = '0;

   logic dst_live;

   assign dst_live = dst_wen_i && (dst_i != ZERO_IDX);
   assign hit_o    = src_en_i && dst_live && (src_i == dst_i);
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
   import hzd_pkg::*;
#(
   parameter int AW     = 5,
   parameter bit FWD_EN = 1'b1
) (
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] mem_rd_i,
   input  logic          mem_wen_i,
   input  logic          mem_load_i,
   input  logic [AW-1:0] wb_rd_i,
   input  logic          wb_wen_i,
   output opsel_e        sel_o
);
   logic mem_hit;
   logic wb_hit;
   logic mem_usable;

   hzd_reg_match #(.AW(AW)) u_mem_cmp (
      .src_i     (src_i),
      .src_en_i  (1'b1),
      .dst_i     (mem_rd_i),
      .dst_wen_i (mem_wen_i),
      .hit_o     (mem_hit)
   );

   hzd_reg_match #(.AW(AW)) u_wb_cmp (
      .src_i     (src_i),
      .src_en_i  (1'b1),
      .dst_i     (wb_rd_i),
      .dst_wen_i (wb_wen_i),
      .hit_o     (wb_hit)
   );

   // A load's data is not yet in the memory-stage register.
   assign mem_usable = mem_hit && !mem_load_i;

   always_comb begin
      sel_o = OPSEL_RF;
      if (FWD_EN) begin
         if (mem_usable)  sel_o = OPSEL_MEM;
         else if (wb_hit) sel_o = OPSEL_WB;
      end
   end
endmodule

// File: rtl/hzd_stall_det.sv
module hzd_stall_det
   import hzd_pkg::*;
#(
   parameter int AW   = 5,
   parameter int MODE = HZ_COMBINED
) (
   input  logic [AW-1:0] id_rs_i  [2],
   input  logic          id_use_i [2],
   input  logic [AW-1:0] ex_rd_i,
   input  logic          ex_wen_i,
   input  logic          ex_load_i,
   input  logic [AW-1:0] mem_rd_i,
   input  logic          mem_wen_i,
   output logic          stall_o
);
   localparam bit WATCH_ALL  = (MODE == HZ_STALL_ONLY);
   localparam bit WATCH_LOAD = (MODE == HZ_COMBINED);

   logic [1:0] hit_ex;
   logic [1:0] hit_mem;

   for (genvar s = 0; s < 2; s++) begin : g_src
      hzd_reg_match #(.AW(AW)) u_ex_cmp (
         .src_i     (id_rs_i[s]),
         .src_en_i  (id_use_i[s]),
         .dst_i     (ex_rd_i),
         .dst_wen_i (ex_wen_i),
         .hit_o     (hit_ex[s])
      );
      hzd_reg_match #(.AW(AW)) u_mem_cmp (
         .src_i     (id_rs_i[s]),
         .src_en_i  (id_use_i[s]),
         .dst_i     (mem_rd_i),
         .dst_wen_i (mem_wen_i),
         .hit_o     (hit_mem[s])
      );
   end

   always_comb begin
      stall_o = 1'b0;
      if (WATCH_ALL)  stall_o = (|hit_ex) || (|hit_mem);
      if (WATCH_LOAD) stall_o = ex_load_i && (|hit_ex);
   end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hzd_pkg::*;
#(
   parameter int MODE   = 2,
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] id_rs1_i,
   input  logic [REG_AW-1:0] id_rs2_i,
   input  logic              id_use_rs1_i,
   input  logic              id_use_rs2_i,
   input  logic [REG_AW-1:0] ex_rs1_i,
   input  logic [REG_AW-1:0] ex_rs2_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_wen_i,
   input  logic              ex_load_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_wen_i,
   input  logic              mem_load_i,
   input  logic [REG_AW-1:0] wb_rd_i,
   input  logic              wb_wen_i,
   output logic [1:0]        fwd_a_sel_o,
   output logic [1:0]        fwd_b_sel_o,
   output logic              pc_hold_o,
   output logic              ifid_hold_o,
   output logic              idex_bubble_o
);
   localparam int  N_OPND   = 2;
   localparam bit  BYPASSES = (MODE != HZ_STALL_ONLY);

   if (!mode_legal(MODE)) begin : g_bad_mode
      $error("hazard_ctrl: MODE must be 0, 1 or 2");
   end
   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_width
      $error("hazard_ctrl: REG_AW must lie in 1..8");
   end

   logic [REG_AW-1:0] id_rs  [N_OPND];
   logic              id_use [N_OPND];
   logic [REG_AW-1:0] ex_rs  [N_OPND];
   opsel_e            sel    [N_OPND];
   logic              freeze;

   assign id_rs[0]  = id_rs1_i;
   assign id_rs[1]  = id_rs2_i;
   assign id_use[0] = id_use_rs1_i;
   assign id_use[1] = id_use_rs2_i;
   assign ex_rs[0]  = ex_rs1_i;
   assign ex_rs[1]  = ex_rs2_i;

   for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
      hzd_fwd_pick #(.AW(REG_AW), .FWD_EN(BYPASSES)) u_pick (
         .src_i      (ex_rs[k]),
         .mem_rd_i   (mem_rd_i),
         .mem_wen_i  (mem_wen_i),
         .mem_load_i (mem_load_i),
         .wb_rd_i    (wb_rd_i),
         .wb_wen_i   (wb_wen_i),
         .sel_o      (sel[k])
      );
   end

   hzd_stall_det #(.AW(REG_AW), .MODE(MODE)) u_stall (
      .id_rs_i   (id_rs),
      .id_use_i  (id_use),
      .ex_rd_i   (ex_rd_i),
      .ex_wen_i  (ex_wen_i),
      .ex_load_i (ex_load_i),
      .mem_rd_i  (mem_rd_i),
      .mem_wen_i (mem_wen_i),
      .stall_o   (freeze)
   );

   assign fwd_a_sel_o   = sel[0];
   assign fwd_b_sel_o   = sel[1];
   assign pc_hold_o     = freeze;
   assign ifid_hold_o   = freeze;
   assign idex_bubble_o = freeze;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
   parameter int MODE   = 2,
   parameter int REG_AW = 5
) (
   input logic [REG_AW-1:0] ex_rs1_i,
   input logic              id_use_rs1_i,
   input logic              id_use_rs2_i,
   input logic              ex_load_i,
   input logic              mem_load_i,
   input logic [1:0]        fwd_a_sel_o,
   input logic [1:0]        fwd_b_sel_o,
   input logic              pc_hold_o,
   input logic              ifid_hold_o,
   input logic              idex_bubble_o
);
   localparam logic [REG_AW-1:0] ZERO_IDX = '0;

   always_comb begin
      assert_hold_agree_R9: assert ((pc_hold_o == ifid_hold_o) && (pc_hold_o == idex_bubble_o))
         else $error("hold outputs disagree");
      assert_sel_legal_R2: assert ((fwd_a_sel_o != 2'b11) && (fwd_b_sel_o != 2'b11))
         else $error("illegal operand select");
      if (MODE == 1)
         assert_fwd_mode_no_stall_R7: assert (!pc_hold_o)
            else $error("forward-only mode froze");
      if (MODE == 0)
         assert_stall_mode_no_bypass_R6: assert ((fwd_a_sel_o == 2'b00) && (fwd_b_sel_o == 2'b00))
            else $error("stall-only mode bypassed");
      if (MODE == 2 && pc_hold_o)
         assert_combined_needs_load_R8: assert (ex_load_i)
            else $error("combined freeze without a load in execute");
      if (ex_rs1_i == ZERO_IDX)
         assert_zero_reg_R4: assert (fwd_a_sel_o == 2'b00)
            else $error("register 0 bypassed");
      if (!id_use_rs1_i && !id_use_rs2_i)
         assert_unused_src_R10: assert (!pc_hold_o)
            else $error("freeze with no used source");
      if (mem_load_i)
         assert_load_not_mem_R5: assert ((fwd_a_sel_o != 2'b10) && (fwd_b_sel_o != 2'b10))
            else $error("load bypassed from memory stage");
   end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.MODE(MODE), .REG_AW(REG_AW)) u_chk (
   .ex_rs1_i      (ex_rs1_i),
   .id_use_rs1_i  (id_use_rs1_i),
   .id_use_rs2_i  (id_use_rs2_i),
   .ex_load_i     (ex_load_i),
   .mem_load_i    (mem_load_i),
   .fwd_a_sel_o   (fwd_a_sel_o),
   .fwd_b_sel_o   (fwd_b_sel_o),
   .pc_hold_o     (pc_hold_o),
   .ifid_hold_o   (ifid_hold_o),
   .idex_bubble_o (idex_bubble_o)
);

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;
   localparam int AW = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic          use1, use2, ex_wen, ex_load, mem_wen, mem_load, wb_wen;

   logic [1:0] sa [3];
   logic [1:0] sb [3];
   logic       ph [3];
   logic       ih [3];
   logic       bb [3];

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   hazard_ctrl #(.MODE(0), .REG_AW(AW)) u_hazard_ctrl_stall (
      .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(use1), .id_use_rs2_i(use2),
      .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_wen_i(ex_wen),
      .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
      .wb_rd_i(wb_rd), .wb_wen_i(wb_wen), .fwd_a_sel_o(sa[0]), .fwd_b_sel_o(sb[0]),
      .pc_hold_o(ph[0]), .ifid_hold_o(ih[0]), .idex_bubble_o(bb[0]));

   hazard_ctrl #(.MODE(1), .REG_AW(AW)) u_hazard_ctrl_fwd (
      .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(use1), .id_use_rs2_i(use2),
      .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_wen_i(ex_wen),
      .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
      .wb_rd_i(wb_rd), .wb_wen_i(wb_wen), .fwd_a_sel_o(sa[1]), .fwd_b_sel_o(sb[1]),
      .pc_hold_o(ph[1]), .ifid_hold_o(ih[1]), .idex_bubble_o(bb[1]));

   hazard_ctrl #(.MODE(2), .REG_AW(AW)) u_hazard_ctrl (
      .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(use1), .id_use_rs2_i(use2),
      .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd), .ex_wen_i(ex_wen),
      .ex_load_i(ex_load), .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
      .wb_rd_i(wb_rd), .wb_wen_i(wb_wen), .fwd_a_sel_o(sa[2]), .fwd_b_sel_o(sb[2]),
      .pc_hold_o(ph[2]), .ifid_hold_o(ih[2]), .idex_bubble_o(bb[2]));

   // Expected select per R2, R3, R4, R5, R6.
   function automatic logic [1:0] exp_sel(input int mode, input logic [AW-1:0] src);
      if (mode == 0) return 2'b00;
      if (mem_wen && mem_rd != 0 && mem_rd == src && !mem_load) return 2'b10;
      if (wb_wen && wb_rd != 0 && wb_rd == src) return 2'b01;
      return 2'b00;
   endfunction

   // Expected freeze per R4, R6, R7, R8, R10.
   function automatic logic exp_stall(input int mode);
      logic hx, hm;
      hx = (use1 && ex_wen && ex_rd != 0 && id_rs1 == ex_rd) ||
           (use2 && ex_wen && ex_rd != 0 && id_rs2 == ex_rd);
      hm = (use1 && mem_wen && mem_rd != 0 && id_rs1 == mem_rd) ||
           (use2 && mem_wen && mem_rd != 0 && id_rs2 == mem_rd);
      if (mode == 0) return hx || hm;
      if (mode == 2) return hx && ex_load;
      return 1'b0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One check per mode covering all outputs against the model.
   task automatic check_all(input string tag);
      for (int m = 0; m < 3; m++) begin
         logic [6:0] act, exp;
         logic st;
         st  = exp_stall(m);
         act = {sa[m], sb[m], ph[m], ih[m], bb[m]};
         exp = {exp_sel(m, ex_rs1), exp_sel(m, ex_rs2), st, st, st};
         chk($sformatf("%s mode%0d", tag, m), int'(act), int'(exp));
      end
   endtask

   task automatic clear();
      {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
      {use1, use2, ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
   endtask

   task automatic settle();
      #1;
   endtask

   initial begin
      clear();
      @(negedge clk); settle();
      // Idle pipe: R2 selects register file, no freeze.
      chk("R2 idle sel", int'(sa[2]), 0);
      chk("R9 idle hold", int'({ph[2], ih[2], bb[2]}), 0);

      // R4: destination 0 with load and write-enable never freezes or bypasses.
      @(negedge clk); clear();
      use1 = 1; ex_wen = 1; ex_load = 1; mem_wen = 1; wb_wen = 1; settle();
      chk("R4 x0 stall combined", int'(ph[2]), 0);
      chk("R4 x0 stall only", int'(ph[0]), 0);
      chk("R4 x0 sel", int'(sa[2]), 0);

      // R4: write-enable low.
      @(negedge clk); clear();
      id_rs1 = 2; use1 = 1; ex_rd = 2; ex_load = 1; mem_rd = 2; ex_rs1 = 2; wb_rd = 2; settle();
      chk("R4 wen low stall", int'(ph[0] | ph[2]), 0);
      chk("R4 wen low sel", int'(sa[1]), 0);

      // R10: unused second source matches a load.
      @(negedge clk); clear();
      id_rs2 = 3; use2 = 0; use1 = 1; id_rs1 = 1; ex_rd = 3; ex_wen = 1; ex_load = 1; settle();
      chk("R10 unused src combined", int'(ph[2]), 0);
      chk("R10 unused src stall only", int'(ph[0]), 0);

      // R3: both later stages match, memory stage wins.
      @(negedge clk); clear();
      ex_rs2 = 1; mem_rd = 1; mem_wen = 1; wb_rd = 1; wb_wen = 1; settle();
      chk("R3 priority", int'(sb[2]), 2);

      // R5: memory-stage load falls through to writeback, then to register file.
      mem_load = 1; settle();
      chk("R5 load to wb", int'(sb[1]), 1);
      wb_rd = 2; settle();
      chk("R5 load to rf", int'(sb[1]), 0);

      // R6: writeback match alone never freezes in stall-only mode.
      @(negedge clk); clear();
      id_rs1 = 1; use1 = 1; wb_rd = 1; wb_wen = 1; settle();
      chk("R6 wb no stall", int'(ph[0]), 0);
      mem_rd = 1; mem_wen = 1; settle();
      chk("R6 mem stall", int'(ph[0]), 1);

      // R11: load-use sequence in combined mode.
      @(negedge clk); clear();
      ex_rd = 1; ex_wen = 1; ex_load = 1; id_rs1 = 1; use1 = 1; settle();
      chk("R11 cycle1 stall", int'(ph[2]), 1);
      chk("R8 load-use stall", int'(bb[2]), 1);
      chk("R7 no stall fwd", int'(ph[1]), 0);
      @(negedge clk); clear();
      mem_rd = 1; mem_wen = 1; mem_load = 1; id_rs1 = 1; use1 = 1; settle();
      chk("R11 cycle2 no stall", int'(ph[2]), 0);
      @(negedge clk); clear();
      wb_rd = 1; wb_wen = 1; ex_rs1 = 1; settle();
      chk("R11 cycle3 wb bypass", int'(sa[2]), 1);

      // Exhaustive sweep of the 2-bit configuration: R1 three modes, R2..R10.
      for (int v = 0; v < (1 << 17); v++) begin
         @(negedge clk);
         id_rs1   = v[1:0];   id_rs2  = v[3:2];
         use1     = v[4];     use2    = v[5];
         ex_rd    = v[7:6];   ex_wen  = v[8];  ex_load = v[9];
         mem_rd   = v[11:10]; mem_wen = v[12]; mem_load = v[13];
         wb_rd    = v[15:14]; wb_wen  = v[16];
         ex_rs1   = v[1:0] ^ v[3:2];
         ex_rs2   = v[3:2];
         settle();
         check_all("R1 sweep");
      end

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule